// File: doc/BRIEF.md
# Multiplexed ISA-style memory target interface

This block attaches a small on-chip byte memory to a reduced ISA-like bus. On that bus, one set of 16 shared lines carries the low address first and the data afterwards. The upper four address bits travel on their own lines. A latch strobe tells the target when the shared lines hold an address. The target stores that address and reuses it for every following data phase until the next strobe arrives.

A memory command is served only when all three of these hold:

- the address enable input is low, so the cycle is not a DMA or refresh cycle;
- the ROM select input is high;
- the latched 20-bit address falls inside a parameterised window.

Reads return data through per-lane output enables, because the shared lines are bidirectional at the pins. Writes are committed when the write strobe rises. The byte-high enable input and address bit 0 decide which bytes move on which lanes.

All inputs are sampled on the rising edge of `clk`. The pad ring uses `bus_ad_o` and `bus_oe_o` to build the tri-state drivers.

Top module: `isa_mux_mem_target`

## Requirements
- R1: After reset, `bus_oe_o` is 2'b00.
- R2: The address is captured on a clock edge where `addr_stb_i` is high. Bits [15:0] come from `bus_ad_i` and bits [19:16] come from `addr_hi_i`. The captured address is held for all later read and write phases until the next strobe.
- R3: The target serves a cycle only when WIN_BASE <= address < WIN_BASE+MEM_BYTES. Outside that window it never drives the bus and never changes memory.
- R4: These are the read lane rules, where `bus_oe_o[0]` enables lane [7:0] and `bus_oe_o[1]` enables lane [15:8]:
  - With `bhe_n_i` low, the even byte of the word goes on [7:0], the odd byte goes on [15:8], and `bus_oe_o` is 2'b11.
  - With `bhe_n_i` high, the byte selected by address bit 0 goes on [7:0] and `bus_oe_o` is 2'b01.
- R5: A cycle with `aen_i` high is ignored: there is no drive and no memory change.
- R6: A cycle with `romsel_n_i` low is ignored: there is no drive and no memory change.
- R7: Read drive timing:
  - `bus_oe_o` becomes non-zero on the clock edge after `memr_n_i` is sampled low in a qualifying cycle.
  - It returns to 2'b00 on the clock edge after `memr_n_i` is sampled high.
- R8: A write commits on the first clock edge where `memw_n_i` is sampled high after being low. It stores the shared-line value sampled in the last cycle the strobe was low, using the lanes of R4 (a word when `bhe_n_i` is low).
- R9: A byte write (`bhe_n_i` high) changes only the byte selected by address bit 0. It takes that byte from [7:0] and ignores [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ad_i | input | 16 | Shared address/data lines, as received |
| bus_ad_o | output | 16 | Read data toward the shared lines |
| bus_oe_o | output | 2 | Lane output enables: bit 0 for [7:0], bit 1 for [15:8] |
| addr_hi_i | input | 4 | Address bits [19:16] |
| addr_stb_i | input | 1 | Address latch strobe, active high |
| aen_i | input | 1 | Address enable; high marks a DMA or refresh cycle |
| bhe_n_i | input | 1 | Byte-high enable, active low |
| romsel_n_i | input | 1 | ROM select, active low |
| memr_n_i | input | 1 | Memory read strobe, active low |
| memw_n_i | input | 1 | Memory write strobe, active low |

## Verification
Any wrong internal state in this block shows up at the ports within one or two clocks:

- A stale or corrupted latched address appears on the next read phase, either as wrong data or as a missing or spurious output enable.
- A bad write qualifier or a bad lane choice leaves a wrong byte in memory. That byte is exposed by the next read of the same word, which the bench performs right after each write and after each ignored cycle.
- A stuck output enable is caught one clock after the read strobe rises.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;   // latched 20-bit address
        logic              wr_n;   // previous sample of write strobe
        logic [DATA_W-1:0] wdata;  // last data seen while write strobe low
        logic              wqual;  // write cycle qualified
        logic              wword;  // write uses both lanes
        logic [LANES-1:0]  oe;     // lane output enables
        logic [DATA_W-1:0] rdata;  // registered read data
    } tgt_state_t;
endpackage

// File: rtl/isa_tgt_window.sv
module isa_tgt_window
    import isa_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 20'hC8000,
    parameter int                SIZE = 256,
    localparam int               OFS_W = $clog2(SIZE)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(SIZE);
    logic [ADDR_W:0] diff;

    always_comb begin
        diff = {1'b0, addr} - {1'b0, BASE};
        hit  = !diff[ADDR_W] && (diff < SIZE_X);
        ofs  = diff[OFS_W-1:0];
    end
endmodule

// File: rtl/isa_tgt_bank.sv
module isa_tgt_bank #(
    parameter int  DEPTH = 128,
    parameter int  WIDTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/isa_mux_mem_target.sv
module isa_mux_mem_target
    import isa_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC8000,
    parameter int                MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic [LANES-1:0]  bus_oe_o,
    input  logic [HI_W-1:0]   addr_hi_i,
    input  logic              addr_stb_i,
    input  logic              aen_i,
    input  logic              bhe_n_i,
    input  logic              romsel_n_i,
    input  logic              memr_n_i,
    input  logic              memw_n_i
);
    localparam int OFS_W = $clog2(MEM_BYTES);
    localparam int WORDS = MEM_BYTES / LANES;
    localparam int WA_W  = OFS_W - 1;

    tgt_state_t st_q, st_d;

    logic              win_hit;
    logic [OFS_W-1:0]  win_ofs;
    logic [WA_W-1:0]   word_adr;
    logic              odd_byte;
    logic              cyc_ok;
    logic              commit;
    logic [LANES-1:0]  bank_we;
    logic [LANE_W-1:0] bank_wd [LANES];
    logic [LANE_W-1:0] bank_rd [LANES];

    isa_tgt_window #(.BASE(WIN_BASE), .SIZE(MEM_BYTES)) u_win (
        .addr (st_q.addr),
        .hit  (win_hit),
        .ofs  (win_ofs)
    );

    assign word_adr = win_ofs[OFS_W-1:1];
    assign odd_byte = win_ofs[0];

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        isa_tgt_bank #(.DEPTH(WORDS), .WIDTH(LANE_W)) u_bank (
            .clk   (clk),
            .we    (bank_we[g]),
            .waddr (word_adr),
            .wdata (bank_wd[g]),
            .raddr (word_adr),
            .rdata (bank_rd[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        cyc_ok = !aen_i && romsel_n_i && win_hit;

        // address phase
        if (addr_stb_i) st_d.addr = {addr_hi_i, bus_ad_i};

        // write phase: track data while strobe low, commit on its rise
        st_d.wr_n = memw_n_i;
        if (!memw_n_i) begin
            st_d.wdata = bus_ad_i;
            st_d.wqual = cyc_ok;
            st_d.wword = !bhe_n_i;
        end
        commit     = !st_q.wr_n && memw_n_i && st_q.wqual;
        bank_we[0] = commit && (st_q.wword || !odd_byte);
        bank_we[1] = commit && (st_q.wword || odd_byte);
        bank_wd[0] = st_q.wdata[LANE_W-1:0];
        bank_wd[1] = st_q.wword ? st_q.wdata[DATA_W-1:LANE_W]
                                : st_q.wdata[LANE_W-1:0];

        // read phase
        st_d.oe    = '0;
        st_d.rdata = '0;
        if (cyc_ok && !memr_n_i) begin
            st_d.oe = {!bhe_n_i, 1'b1};
            if (!bhe_n_i)
                st_d.rdata = {bank_rd[1], bank_rd[0]};
            else
                st_d.rdata = {{LANE_W{1'b0}}, odd_byte ? bank_rd[1] : bank_rd[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.wr_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ad_o = st_q.rdata;
    assign bus_oe_o = st_q.oe;
endmodule

// File: rtl/isa_tgt_checker.sv
module isa_tgt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       aen_i,
    input logic       romsel_n_i,
    input logic       memr_n_i,
    input logic       bhe_n_i,
    input logic       win_hit,
    input logic [1:0] bus_oe_o
);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> bus_oe_o == 2'b00);

    a_r3_no_drive_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_hit) |-> bus_oe_o == 2'b00);

    a_r5_dma_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(aen_i) |-> bus_oe_o == 2'b00);

    a_r6_rom_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(romsel_n_i) |-> bus_oe_o == 2'b00);

    a_r7_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(memr_n_i) |-> bus_oe_o == 2'b00);

    a_r4_high_lane_needs_bhe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bhe_n_i) |-> !bus_oe_o[1]);

    a_r4_low_lane_always: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o[1] |-> bus_oe_o[0]);
endmodule

bind isa_mux_mem_target isa_tgt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aen_i      (aen_i),
    .romsel_n_i (romsel_n_i),
    .memr_n_i   (memr_n_i),
    .bhe_n_i    (bhe_n_i),
    .win_hit    (win_hit),
    .bus_oe_o   (bus_oe_o)
);

// File: tb/tb_isa_mux_mem_target.sv
module tb_isa_mux_mem_target;
    localparam logic [19:0] BASE  = 20'hC8000;
    localparam int          BYTES = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_ad_i = '0;
    logic [15:0] bus_ad_o;
    logic [1:0]  bus_oe_o;
    logic [3:0]  addr_hi_i = '0;
    logic        addr_stb_i = 1'b0;
    logic        aen_i = 1'b0;
    logic        bhe_n_i = 1'b1;
    logic        romsel_n_i = 1'b1;
    logic        memr_n_i = 1'b1;
    logic        memw_n_i = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [7:0]  model [BYTES];
    logic [19:0] cur_addr = '0;

    logic [1:0]  exp_oe_q [$];
    logic [15:0] exp_dat_q [$];
    string       exp_tag_q [$];
    logic        mon_go = 1'b0;

    always #4 clk = ~clk;

    isa_mux_mem_target #(.WIN_BASE(BASE), .MEM_BYTES(BYTES)) dut (
        .clk, .rst_n, .bus_ad_i, .bus_ad_o, .bus_oe_o, .addr_hi_i,
        .addr_stb_i, .aen_i, .bhe_n_i, .romsel_n_i, .memr_n_i, .memw_n_i
    );

    function automatic logic in_win(input logic [19:0] a);
        return (a >= BASE) && (a < BASE + 20'(BYTES));
    endfunction

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results and compares them
    always @(negedge clk) begin
        if (mon_go) begin
            logic [1:0]  eo;
            logic [15:0] ed, mask;
            string       t;
            eo = exp_oe_q.pop_front();
            ed = exp_dat_q.pop_front();
            t  = exp_tag_q.pop_front();
            mask = {{8{eo[1]}}, {8{eo[0]}}};
            check(t, (bus_oe_o == eo) && ((bus_ad_o & mask) == (ed & mask)),
                  {14'b0, bus_oe_o, bus_ad_o & mask}, {14'b0, eo, ed & mask});
            mon_go = 1'b0;
        end
    end

    task automatic latch(input logic [19:0] a);
        @(negedge clk);
        bus_ad_i = a[15:0]; addr_hi_i = a[19:16]; addr_stb_i = 1'b1;
        @(negedge clk);
        addr_stb_i = 1'b0; bus_ad_i = 16'hA5A5; addr_hi_i = 4'hF;
        cur_addr = a;
    endtask

    task automatic write(input logic bhe_n, input logic [15:0] d, input logic aen, input logic rom_n);
        logic [19:0] ofs;
        @(negedge clk);
        bus_ad_i = d; bhe_n_i = bhe_n; aen_i = aen; romsel_n_i = rom_n; memw_n_i = 1'b0;
        @(negedge clk);
        memw_n_i = 1'b1; bus_ad_i = 16'hDEAD;
        @(negedge clk);
        aen_i = 1'b0; romsel_n_i = 1'b1; bhe_n_i = 1'b1;
        if (!aen && rom_n && in_win(cur_addr)) begin
            ofs = cur_addr - BASE;
            if (!bhe_n) begin
                model[{ofs[7:1], 1'b0}] = d[7:0];
                model[{ofs[7:1], 1'b1}] = d[15:8];
            end else begin
                model[ofs[7:0]] = d[7:0];
            end
        end
    endtask

    task automatic read(input logic bhe_n, input logic aen, input logic rom_n, input string tag);
        logic [19:0] ofs;
        logic [1:0]  eo;
        logic [15:0] ed;
        ofs = cur_addr - BASE;
        eo = 2'b00; ed = '0;
        if (!aen && rom_n && in_win(cur_addr)) begin
            if (!bhe_n) begin
                eo = 2'b11;
                ed = {model[{ofs[7:1], 1'b1}], model[{ofs[7:1], 1'b0}]};
            end else begin
                eo = 2'b01;
                ed = {8'h00, model[ofs[7:0]]};
            end
        end
        @(negedge clk);
        bhe_n_i = bhe_n; aen_i = aen; romsel_n_i = rom_n; memr_n_i = 1'b0;
        @(posedge clk);
        #1;
        exp_oe_q.push_back(eo); exp_dat_q.push_back(ed); exp_tag_q.push_back(tag);
        mon_go = 1'b1;
        @(negedge clk);
        #1;
        memr_n_i = 1'b1;
        @(negedge clk);
        check("R7 release", bus_oe_o == 2'b00, {30'b0, bus_oe_o}, 32'h0);
        aen_i = 1'b0; romsel_n_i = 1'b1; bhe_n_i = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < BYTES; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset", bus_oe_o == 2'b00, {30'b0, bus_oe_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // word write and lane forms of read
        latch(20'hC8010);
        write(1'b0, 16'h1234, 1'b0, 1'b1);
        read(1'b0, 1'b0, 1'b1, "R8 R4 word read");
        read(1'b1, 1'b0, 1'b1, "R4 even byte");
        latch(20'hC8011);
        read(1'b1, 1'b0, 1'b1, "R4 odd byte on low lane");

        // byte write ignores upper lane and keeps the other byte
        write(1'b1, 16'hFFAB, 1'b0, 1'b1);
        latch(20'hC8010);
        read(1'b0, 1'b0, 1'b1, "R9 byte write");

        // back-to-back data phases reuse the latched address
        write(1'b0, 16'h5566, 1'b0, 1'b1);
        write(1'b0, 16'h7788, 1'b0, 1'b1);
        read(1'b0, 1'b0, 1'b1, "R2 held address");

        // window boundaries
        latch(20'hC9010);
        read(1'b0, 1'b0, 1'b1, "R2 R3 upper bits out of window");
        latch(20'hC80FF);
        write(1'b1, 16'h005A, 1'b0, 1'b1);
        read(1'b1, 1'b0, 1'b1, "R3 last byte");
        latch(20'hC8000);
        write(1'b0, 16'h0F0E, 1'b0, 1'b1);
        read(1'b0, 1'b0, 1'b1, "R3 first word");
        latch(20'hC8100);
        write(1'b0, 16'hBEEF, 1'b0, 1'b1);
        read(1'b0, 1'b0, 1'b1, "R3 above window");
        latch(20'hC7FFE);
        write(1'b0, 16'hCAFE, 1'b0, 1'b1);
        read(1'b0, 1'b0, 1'b1, "R3 below window");
        latch(20'hC8000);
        read(1'b0, 1'b0, 1'b1, "R3 no alias write");

        // DMA/refresh cycles
        write(1'b0, 16'h1111, 1'b1, 1'b1);
        read(1'b0, 1'b1, 1'b1, "R5 aen read");
        read(1'b0, 1'b0, 1'b1, "R5 aen write ignored");

        // ROM select active
        write(1'b0, 16'h2222, 1'b0, 1'b0);
        read(1'b0, 1'b0, 1'b0, "R6 rom read");
        read(1'b0, 1'b0, 1'b1, "R6 rom write ignored");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule